// File: doc/BRIEF.md
# Camera Serial Packet Header Screen

This block sits behind the lane merger of a camera serial receiver and sees one 32-bit packet header per valid strobe. It splits the header into its virtual channel, data type and 16-bit word count, verifies the Hamming check byte, and decides whether the packet is passed on or discarded. Each header produces exactly one result pulse one clock later: either an accept pulse with the decoded fields, or a drop pulse.

Three screens can be enabled on their own. The check-byte screen can compute the code over the three payload bytes in any of four byte orders, because image sensors differ in the order they use. The type screen passes only the two raw pixel formats it knows. The length screen passes only long packets whose word count equals a programmed line length. A small status unit keeps the last accepted long packet's data ID and word count and counts accepted lines since the last frame start, so software can learn what the sensor actually sends.

Top module: `csi_hdr_check`

## Requirements
- R1: A header on `hdr_data` is read as: bits [7:0] data ID, bits [15:8] word count low byte, bits [23:16] word count high byte, bits [31:24] check byte. The data ID carries the virtual channel in bits [7:6] and the data type in bits [5:0]. For every cycle with `hdr_valid` high, exactly one of `pkt_valid` or `pkt_drop` pulses high in the next cycle; with `hdr_valid` low neither pulses in the next cycle.
- R2: On an accept pulse, `pkt_vc`, `pkt_dt` and `pkt_wc` show the header's fields, and `pkt_long` is 1 when the data type is above 0x0F and 0 for types 0x00 to 0x0F (short packets).
- R3: With `cfg_ecc_en` high, a header is dropped unless its check byte equals the 6-bit Hamming code of the 24 payload bits with bits [7:6] zero. With `cfg_ecc_en` low the check byte has no effect on the result.
- R4: `cfg_ecc_order` places the three payload bytes into code bits [7:0], [15:8], [23:16] as follows: 3 = data ID, WC low, WC high; 2 = data ID, WC high, WC low; 1 = WC low, WC high, data ID; 0 = WC high, WC low, data ID.
- R5: With `cfg_dt_en` high, a long packet is dropped unless its data type is 0x2A or 0x2B; short packets are not subject to this screen.
- R6: With `cfg_wc_en` high, a long packet is dropped unless its word count equals `cfg_wc_ref`; short packets are not subject to this screen.
- R7: `stat_di` and `stat_wc` take the data ID and word count of each accepted long packet in the cycle its accept pulse shows, and keep their value across dropped headers and short packets.
- R8: `stat_rows` clears to 0 on an accepted short packet of type 0x00 (frame start), increments by one on each accepted long packet, and otherwise holds.
- R9: Synchronous reset `rst` clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_data | input | 32 | Packet header (check byte, WC high, WC low, data ID) |
| cfg_ecc_en | input | 1 | Enable check-byte screen |
| cfg_ecc_order | input | 2 | Byte order fed to the check-byte code |
| cfg_dt_en | input | 1 | Enable data-type screen |
| cfg_wc_en | input | 1 | Enable word-count screen |
| cfg_wc_ref | input | 16 | Expected long-packet word count |
| pkt_valid | output | 1 | Header accepted (one-cycle pulse) |
| pkt_drop | output | 1 | Header rejected (one-cycle pulse) |
| pkt_long | output | 1 | Accepted header is a long packet |
| pkt_vc | output | 2 | Virtual channel |
| pkt_dt | output | 6 | Data type |
| pkt_wc | output | 16 | Word count |
| stat_di | output | 8 | Last accepted long packet data ID |
| stat_wc | output | 16 | Last accepted long packet word count |
| stat_rows | output | 16 | Long packets accepted since frame start |

## Verification
A wrong byte permutation or parity mask shows up in the very next cycle as a drop pulse where an accept was due, so each of the four orders is exercised with headers whose bytes all differ. A screen decision that leaks into short packets or ignores its enable likewise flips the result pulse one cycle after the header. Corrupted status state is only visible on the status outputs, so the line counter and the captured fields are compared after every header, including dropped ones, which must leave them unchanged.

// File: rtl/csi_hdr_pkg.sv
package csi_hdr_pkg;

    localparam int BYTE_W   = 8;
    localparam int WC_W     = 16;
    localparam int DT_W     = 6;
    localparam int VC_W     = 2;
    localparam int PAYLD_W  = 3 * BYTE_W;
    localparam int PAR_BITS = 6;

    localparam logic [DT_W-1:0] DT_FRAME_START = 6'h00;
    localparam logic [DT_W-1:0] DT_SHORT_MAX   = 6'h0F;
    localparam logic [DT_W-1:0] DT_RAW8        = 6'h2A;
    localparam logic [DT_W-1:0] DT_RAW10       = 6'h2B;

    typedef enum logic [1:0] {
        ORD_WH_WL_DI = 2'd0,
        ORD_WL_WH_DI = 2'd1,
        ORD_DI_WH_WL = 2'd2,
        ORD_DI_WL_WH = 2'd3
    } ecc_order_e;

    // Packed header: last member lands at the low bits.
    typedef struct packed {
        logic [BYTE_W-1:0] chk;
        logic [BYTE_W-1:0] wc_hi;
        logic [BYTE_W-1:0] wc_lo;
        logic [BYTE_W-1:0] di;
    } hdr_t;

    typedef struct packed {
        logic            is_long;
        logic [VC_W-1:0] vc;
        logic [DT_W-1:0] dt;
        logic [WC_W-1:0] wc;
    } fields_t;

    // Bits of the 24-bit payload that feed each parity bit.
    function automatic logic [PAYLD_W-1:0] parity_mask(input int idx);
        case (idx)
            0:       return 24'hF12CB7;
            1:       return 24'hF2555B;
            2:       return 24'h749A6D;
            3:       return 24'hB8E38E;
            4:       return 24'hDF03F0;
            default: return 24'hEFFC00;
        endcase
    endfunction

    // Place the three payload bytes; the first named byte goes to [7:0].
    function automatic logic [PAYLD_W-1:0] order_bytes(
        input logic [BYTE_W-1:0] di,
        input logic [BYTE_W-1:0] lo,
        input logic [BYTE_W-1:0] hi,
        input ecc_order_e        ord
    );
        case (ord)
            ORD_DI_WL_WH: return {hi, lo, di};
            ORD_DI_WH_WL: return {lo, hi, di};
            ORD_WL_WH_DI: return {di, hi, lo};
            default:      return {di, lo, hi};
        endcase
    endfunction

    function automatic fields_t decode_hdr(input hdr_t h);
        fields_t f;
        f.vc      = h.di[BYTE_W-1 -: VC_W];
        f.dt      = h.di[DT_W-1:0];
        f.wc      = {h.wc_hi, h.wc_lo};
        f.is_long = (f.dt > DT_SHORT_MAX);
        return f;
    endfunction

endpackage

// File: rtl/csi_hdr_ecc_calc.sv
module csi_hdr_ecc_calc
    import csi_hdr_pkg::*;
(
    input  logic [BYTE_W-1:0] di,
    input  logic [BYTE_W-1:0] wc_lo,
    input  logic [BYTE_W-1:0] wc_hi,
    input  logic [1:0]        order,
    output logic [BYTE_W-1:0] chk_calc
);
    localparam int PAD_W = BYTE_W - PAR_BITS;

    logic [PAYLD_W-1:0]  payload;
    logic [PAR_BITS-1:0] par;

    assign payload = order_bytes(di, wc_lo, wc_hi, ecc_order_e'(order));

    for (genvar g = 0; g < PAR_BITS; g++) begin : g_par
        assign par[g] = ^(payload & parity_mask(g));
    end

    assign chk_calc = {{PAD_W{1'b0}}, par};

endmodule

// File: rtl/csi_hdr_screen.sv
module csi_hdr_screen
    import csi_hdr_pkg::*;
(
    input  fields_t           f,
    input  logic [BYTE_W-1:0] chk_rx,
    input  logic [BYTE_W-1:0] chk_calc,
    input  logic              ecc_en,
    input  logic              dt_en,
    input  logic              wc_en,
    input  logic [WC_W-1:0]   wc_ref,
    output logic              accept
);
    logic ecc_ok;
    logic dt_ok;
    logic wc_ok;

    always_comb begin
        ecc_ok = !ecc_en || (chk_rx == chk_calc);
        dt_ok  = !dt_en || !f.is_long || (f.dt == DT_RAW8) || (f.dt == DT_RAW10);
        wc_ok  = !wc_en || !f.is_long || (f.wc == wc_ref);
        accept = ecc_ok && dt_ok && wc_ok;
    end

endmodule

// File: rtl/csi_hdr_stats.sv
module csi_hdr_stats
    import csi_hdr_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  fields_t           f,
    output logic [BYTE_W-1:0] stat_di,
    output logic [WC_W-1:0]   stat_wc,
    output logic [ROW_W-1:0]  stat_rows
);
    logic frame_start;

    assign frame_start = !f.is_long && (f.dt == DT_FRAME_START);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_di   <= '0;
            stat_wc   <= '0;
            stat_rows <= '0;
        end else if (take) begin
            if (f.is_long) begin
                stat_di   <= {f.vc, f.dt};
                stat_wc   <= f.wc;
                stat_rows <= stat_rows + 1'b1;
            end else if (frame_start) begin
                stat_rows <= '0;
            end
        end
    end

endmodule

// File: rtl/csi_hdr_check.sv
module csi_hdr_check
    import csi_hdr_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_valid,
    input  logic [31:0]       hdr_data,
    input  logic              cfg_ecc_en,
    input  logic [1:0]        cfg_ecc_order,
    input  logic              cfg_dt_en,
    input  logic              cfg_wc_en,
    input  logic [15:0]       cfg_wc_ref,
    output logic              pkt_valid,
    output logic              pkt_drop,
    output logic              pkt_long,
    output logic [1:0]        pkt_vc,
    output logic [5:0]        pkt_dt,
    output logic [15:0]       pkt_wc,
    output logic [7:0]        stat_di,
    output logic [15:0]       stat_wc,
    output logic [ROW_W-1:0]  stat_rows
);
    hdr_t              hdr;
    fields_t           fld;
    fields_t           fld_q;
    logic [BYTE_W-1:0] chk_calc;
    logic              accept;
    logic              take;

    assign hdr  = hdr_t'(hdr_data);
    assign fld  = decode_hdr(hdr);
    assign take = hdr_valid && accept;

    csi_hdr_ecc_calc u_ecc (
        .di       (hdr.di),
        .wc_lo    (hdr.wc_lo),
        .wc_hi    (hdr.wc_hi),
        .order    (cfg_ecc_order),
        .chk_calc (chk_calc)
    );

    csi_hdr_screen u_screen (
        .f        (fld),
        .chk_rx   (hdr.chk),
        .chk_calc (chk_calc),
        .ecc_en   (cfg_ecc_en),
        .dt_en    (cfg_dt_en),
        .wc_en    (cfg_wc_en),
        .wc_ref   (cfg_wc_ref),
        .accept   (accept)
    );

    csi_hdr_stats #(.ROW_W(ROW_W)) u_stats (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .f         (fld),
        .stat_di   (stat_di),
        .stat_wc   (stat_wc),
        .stat_rows (stat_rows)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_valid <= 1'b0;
            pkt_drop  <= 1'b0;
            fld_q     <= '0;
        end else begin
            pkt_valid <= take;
            pkt_drop  <= hdr_valid && !accept;
            if (take) begin
                fld_q <= fld;
            end
        end
    end

    assign pkt_long = fld_q.is_long;
    assign pkt_vc   = fld_q.vc;
    assign pkt_dt   = fld_q.dt;
    assign pkt_wc   = fld_q.wc;

endmodule

// File: rtl/csi_hdr_check_sva.sv
module csi_hdr_check_sva #(
    parameter int ROW_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             hdr_valid,
    input logic [31:0]      hdr_data,
    input logic             cfg_ecc_en,
    input logic [1:0]       cfg_ecc_order,
    input logic             cfg_dt_en,
    input logic             cfg_wc_en,
    input logic [15:0]      cfg_wc_ref,
    input logic             pkt_valid,
    input logic             pkt_drop,
    input logic             pkt_long,
    input logic [1:0]       pkt_vc,
    input logic [5:0]       pkt_dt,
    input logic [15:0]      pkt_wc,
    input logic [7:0]       stat_di,
    input logic [15:0]      stat_wc,
    input logic [ROW_W-1:0] stat_rows
);
    logic hdr_long;
    assign hdr_long = hdr_data[5:0] > 6'h0F;

    a_r1_one_result: assert property (@(posedge clk) disable iff (rst)
        !(pkt_valid && pkt_drop));

    a_r1_result_follows: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> (pkt_valid || pkt_drop));

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !hdr_valid |=> !(pkt_valid || pkt_drop));

    a_r3_top_bits_reject: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && cfg_ecc_en && (hdr_data[31:30] != 2'b00)) |=> pkt_drop);

    a_r5_type_reject: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && cfg_dt_en && hdr_long &&
         (hdr_data[5:0] != 6'h2A) && (hdr_data[5:0] != 6'h2B)) |=> pkt_drop);

    a_r6_count_reject: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && cfg_wc_en && hdr_long &&
         (hdr_data[23:8] != cfg_wc_ref)) |=> pkt_drop);

    a_r7_stat_matches: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_long) |-> (stat_di == {pkt_vc, pkt_dt} && stat_wc == pkt_wc));

    a_r8_rows_clear: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_long && pkt_dt == 6'h00) |-> (stat_rows == '0));

    a_r8_rows_hold: assert property (@(posedge clk) disable iff (rst)
        !hdr_valid |=> $stable(stat_rows));

endmodule

bind csi_hdr_check csi_hdr_check_sva #(.ROW_W(ROW_W)) u_sva (.*);

// File: tb/csi_hdr_check_tb.sv
module csi_hdr_check_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hdr_valid = 1'b0;
    logic [31:0] hdr_data = '0;
    logic        cfg_ecc_en = 1'b1;
    logic [1:0]  cfg_ecc_order = 2'd3;
    logic        cfg_dt_en = 1'b0;
    logic        cfg_wc_en = 1'b0;
    logic [15:0] cfg_wc_ref = '0;
    logic        pkt_valid, pkt_drop, pkt_long;
    logic [1:0]  pkt_vc;
    logic [5:0]  pkt_dt;
    logic [15:0] pkt_wc, stat_wc, stat_rows;
    logic [7:0]  stat_di;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0]  exp_di = '0;
    logic [15:0] exp_wc = '0;
    logic [15:0] exp_rows = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csi_hdr_check u_dut (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
        .cfg_ecc_en(cfg_ecc_en), .cfg_ecc_order(cfg_ecc_order),
        .cfg_dt_en(cfg_dt_en), .cfg_wc_en(cfg_wc_en), .cfg_wc_ref(cfg_wc_ref),
        .pkt_valid(pkt_valid), .pkt_drop(pkt_drop), .pkt_long(pkt_long),
        .pkt_vc(pkt_vc), .pkt_dt(pkt_dt), .pkt_wc(pkt_wc),
        .stat_di(stat_di), .stat_wc(stat_wc), .stat_rows(stat_rows)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Hamming parity written bit by bit.
    function automatic logic [7:0] ham(input logic [23:0] d);
        logic [5:0] p;
        p[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
        p[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
        p[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
        p[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
        p[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
        p[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
        return {2'b00, p};
    endfunction

    // R4 byte placement, first listed byte at bits [7:0].
    function automatic logic [7:0] chk_for(input logic [7:0] di, input logic [15:0] wc,
                                           input logic [1:0] ord);
        logic [7:0] lo, hi;
        lo = wc[7:0];
        hi = wc[15:8];
        case (ord)
            2'd3:    return ham({hi, lo, di});
            2'd2:    return ham({lo, hi, di});
            2'd1:    return ham({di, hi, lo});
            default: return ham({di, lo, hi});
        endcase
    endfunction

    // Drive one header, sample its result one cycle later.
    task automatic send(input logic [7:0] di, input logic [15:0] wc, input logic [7:0] chk,
                        input bit exp_acc, input string tag);
        bit lng;
        lng = di[5:0] > 6'h0F;
        @(negedge clk);
        hdr_valid = 1'b1;
        hdr_data  = {chk, wc[15:8], wc[7:0], di};
        @(negedge clk);
        hdr_valid = 1'b0;
        check(pkt_valid == exp_acc, {tag, " R1 accept"}, 32'(pkt_valid), 32'(exp_acc));
        check(pkt_drop == !exp_acc, {tag, " R1 drop"}, 32'(pkt_drop), 32'(!exp_acc));
        if (exp_acc) begin
            check(pkt_long == lng, {tag, " R2 long"}, 32'(pkt_long), 32'(lng));
            check({pkt_vc, pkt_dt} == di, {tag, " R2 di"}, 32'({pkt_vc, pkt_dt}), 32'(di));
            check(pkt_wc == wc, {tag, " R2 wc"}, 32'(pkt_wc), 32'(wc));
            if (lng) begin
                exp_di = di;
                exp_wc = wc;
                exp_rows = exp_rows + 16'd1;
            end else if (di[5:0] == 6'h00) begin
                exp_rows = '0;
            end
        end
        check(stat_di == exp_di, {tag, " R7 stat_di"}, 32'(stat_di), 32'(exp_di));
        check(stat_wc == exp_wc, {tag, " R7 stat_wc"}, 32'(stat_wc), 32'(exp_wc));
        check(stat_rows == exp_rows, {tag, " R8 rows"}, 32'(stat_rows), 32'(exp_rows));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!pkt_valid && !pkt_drop, "R9 result idle", 32'({pkt_valid, pkt_drop}), 0);
        check(pkt_wc == 0 && pkt_dt == 0, "R9 fields zero", 32'({pkt_dt, pkt_wc}), 0);
        check(stat_rows == 0 && stat_di == 0 && stat_wc == 0, "R9 status zero",
              32'({stat_di, stat_rows}), 0);
    endtask

    task automatic t_orders();
        cfg_ecc_en = 1'b1;
        for (int o = 0; o < 4; o++) begin
            cfg_ecc_order = 2'(o);
            send(8'h6A, 16'h0A20, chk_for(8'h6A, 16'h0A20, 2'(o)), 1'b1, "R4 order match");
            send(8'h01, 16'h5C37, chk_for(8'h01, 16'h5C37, 2'(o)), 1'b1, "R4 order short");
        end
        cfg_ecc_order = 2'd1;
        begin
            logic [7:0] c3, c1;
            c3 = chk_for(8'h2B, 16'h0A20, 2'd3);
            c1 = chk_for(8'h2B, 16'h0A20, 2'd1);
            send(8'h2B, 16'h0A20, c3, c3 == c1, "R4 wrong order");
        end
        cfg_ecc_order = 2'd3;
    endtask

    task automatic t_ecc();
        logic [7:0] good;
        good = chk_for(8'h2A, 16'h0440, 2'd3);
        send(8'h2A, 16'h0440, good ^ 8'h04, 1'b0, "R3 single bit flip");
        send(8'h2A, 16'h0440, good | 8'h80, 1'b0, "R3 top bit set");
        cfg_ecc_en = 1'b0;
        send(8'h2A, 16'h0440, good ^ 8'h3F, 1'b1, "R3 disabled ignored");
        cfg_ecc_en = 1'b1;
    endtask

    task automatic t_dtype();
        cfg_dt_en = 1'b1;
        send(8'h2C, 16'h0100, chk_for(8'h2C, 16'h0100, 2'd3), 1'b0, "R5 raw12 dropped");
        send(8'h1E, 16'h0100, chk_for(8'h1E, 16'h0100, 2'd3), 1'b0, "R5 yuv dropped");
        send(8'h6B, 16'h0100, chk_for(8'h6B, 16'h0100, 2'd3), 1'b1, "R5 raw10 kept");
        send(8'h2A, 16'h0102, chk_for(8'h2A, 16'h0102, 2'd3), 1'b1, "R5 raw8 kept");
        send(8'h01, 16'h0007, chk_for(8'h01, 16'h0007, 2'd3), 1'b1, "R5 short exempt");
        cfg_dt_en = 1'b0;
        send(8'h2C, 16'h0100, chk_for(8'h2C, 16'h0100, 2'd3), 1'b1, "R5 disabled");
    endtask

    task automatic t_wcount();
        cfg_wc_en  = 1'b1;
        cfg_wc_ref = 16'h0A20;
        send(8'h2A, 16'h0A21, chk_for(8'h2A, 16'h0A21, 2'd3), 1'b0, "R6 off by one");
        send(8'h2A, 16'h0B20, chk_for(8'h2A, 16'h0B20, 2'd3), 1'b0, "R6 high byte differs");
        send(8'h2A, 16'h0A20, chk_for(8'h2A, 16'h0A20, 2'd3), 1'b1, "R6 equal kept");
        send(8'h02, 16'h1234, chk_for(8'h02, 16'h1234, 2'd3), 1'b1, "R6 short exempt");
        cfg_wc_en = 1'b0;
    endtask

    task automatic t_rows();
        send(8'h00, 16'h0001, chk_for(8'h00, 16'h0001, 2'd3), 1'b1, "R8 frame start");
        for (int i = 0; i < 3; i++)
            send(8'h2A, 16'(16'h0300 + i), chk_for(8'h2A, 16'(16'h0300 + i), 2'd3), 1'b1,
                 "R8 line");
        send(8'h2A, 16'h0399, 8'hC0, 1'b0, "R7 dropped keeps status");
        send(8'h03, 16'h0001, chk_for(8'h03, 16'h0001, 2'd3), 1'b1, "R7 short keeps status");
        send(8'h40, 16'h0002, chk_for(8'h40, 16'h0002, 2'd3), 1'b1, "R8 frame start vc1");
        send(8'hAB, 16'h0CA8, chk_for(8'hAB, 16'h0CA8, 2'd3), 1'b1, "R7 line after restart");
        @(negedge clk);
        check(!pkt_valid && !pkt_drop, "R1 idle no pulse", 32'({pkt_valid, pkt_drop}), 0);
    endtask

    initial begin
        t_reset();
        t_orders();
        t_ecc();
        t_dtype();
        t_wcount();
        t_rows();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule